// File: doc/BRIEF.md
# Bit-Serial Processing Element Register Array

This block is the register side of a word-parallel, bit-serial array. It holds N one-bit processing elements (lanes). Each lane owns one bit of each of three N-bit registers: X, Y and M. A shared N-bit operand F arrives from the permutation network and reaches every lane at the same time. A 4-bit truth-table code chooses any of the sixteen two-input Boolean functions, and every lane applies it to its own register bit and its own F bit.

A 3-bit mode field selects how the registers update. X can update alone, Y can update alone, or both can update with the same function. X can also update only in lanes whose Y bit is set. In a further mode, X updates under the Y value from before the edge while Y itself updates in the same cycle. Register M loads from F on command, and it drives the write-mask bus of the array memory. A resolver watches Y and reports whether any lane is set and the index of the lowest set lane.

A controller outside this block sequences these primitives. For example, it can run a four-step loop per bit slice that adds two fields in every lane at once, leaving each sum slice in Y and the carry in Y between slices.

Top module: `pe_reg_array`

## Requirements
- R1: After reset, X, Y and M are all zero, so `wr_mask_o` is 0, `any_o` is 0 and `first_o` is 0.
- R2: Bit k of `tt_i` gives the result for the input pair {reg, f} = k, with reg as the more significant bit. For example, 4'b0110 is XOR, 4'b1000 is AND, 4'b1010 copies F, 4'b0011 inverts the register bit and 4'b0001 is NOR.
- R3: With `mode_i` = 0, every X bit takes the function of (X, F) at the clock edge, and Y is unchanged.
- R4: With `mode_i` = 1, every Y bit takes the function of (Y, F), and X is unchanged.
- R5: With `mode_i` = 2, X takes the function of (X, F) and Y takes the same function of (Y, F) in the same edge.
- R6: With `mode_i` = 3, X takes the function of (X, F) only in lanes where Y is 1. Lanes where Y is 0 keep their X bit, and Y is unchanged.
- R7: With `mode_i` = 4, X takes the function of (X, F) only in lanes where Y was 1 before the edge, and Y takes the function of (Y, F) in the same edge.
- R8: `mode_i` values 5, 6 and 7 leave X and Y unchanged.
- R9: When `m_ld_i` is 1, M loads F at the edge, whatever the mode. Otherwise M holds its value. `wr_mask_o` always shows M.
- R10: `any_o` is 1 exactly when at least one Y bit is 1. When `any_o` is 0, `first_o` is 0.
- R11: When `any_o` is 1, `first_o` is the lowest index whose Y bit is 1.
- R12: The four-step add loop gives a + b in every lane. Per bit slice, from the least significant bit with X = 0 and Y = carry, the steps are:
  1. mode 4 with XOR of slice a.
  2. mode 4 with XOR of slice b; Y now holds the sum slice.
  3. mode 3 with NOT-register.
  4. mode 2 with XOR of F = X.

  After the last slice, Y holds the carry out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| f_i | input | N | Operand from the permutation network, one bit per lane |
| tt_i | input | 4 | Truth-table code of the two-input function |
| mode_i | input | 3 | Register update mode |
| m_ld_i | input | 1 | Load M from F at this edge |
| x_o | output | N | X register |
| y_o | output | N | Y register |
| wr_mask_o | output | N | M register, used as the memory write mask |
| any_o | output | 1 | Some Y bit is set |
| first_o | output | IW | Index of the lowest set Y bit |

## Verification
Assertions check the following on every cycle:
- The hold rules: Y is untouched by X-only and X-masked updates, both registers are untouched by the idle modes, and M holds unless loaded.
- Masked lanes keep their X bit under the current-Y mask and under the old-Y mask.
- M loads the previous F when commanded.
- The resolver never points at a clear lane and reads zero when nothing is set.

Only the bench scenarios can show that each truth-table code yields the intended function and that `first_o` is the lowest set lane rather than just some set lane. They also show that the four-step loop, chaining the old-Y and current-Y masks, actually produces correct sums and carries in every lane.

// File: rtl/pe_pkg.sv
package pe_pkg;

   typedef enum logic [2:0] {
      UPD_X      = 3'd0,
      UPD_Y      = 3'd1,
      UPD_XY     = 3'd2,
      UPD_X_YMSK = 3'd3,
      UPD_X_OLDY = 3'd4
   } upd_mode_e;

   // truth-table lookup: index is {register bit, operand bit}
   function automatic logic tt_eval(input logic [3:0] tt, input logic r, input logic f);
      return tt[{r, f}];
   endfunction

endpackage

// File: rtl/pe_lane.sv
module pe_lane
   import pe_pkg::*;
(
   input  logic       x_i,
   input  logic       y_i,
   input  logic       f_i,
   input  logic [3:0] tt_i,
   input  logic [2:0] mode_i,
   output logic       x_nx_o,
   output logic       y_nx_o
);
   logic fx, fy;

   always_comb begin
      fx     = tt_eval(tt_i, x_i, f_i);
      fy     = tt_eval(tt_i, y_i, f_i);
      x_nx_o = x_i;
      y_nx_o = y_i;
      case (mode_i)
         UPD_X:      x_nx_o = fx;
         UPD_Y:      y_nx_o = fy;
         UPD_XY: begin
            x_nx_o = fx;
            y_nx_o = fy;
         end
         UPD_X_YMSK: x_nx_o = y_i ? fx : x_i;
         UPD_X_OLDY: begin
            x_nx_o = y_i ? fx : x_i;   // mask uses Y before this edge
            y_nx_o = fy;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pe_resolver.sv
module pe_resolver #(
   parameter int N  = 16,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  y_i,
   output logic          any_o,
   output logic [IW-1:0] first_o
);
   always_comb begin
      any_o   = 1'b0;
      first_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (y_i[i]) begin
            any_o   = 1'b1;
            first_o = IW'(i);
         end
      end
   end
endmodule

// File: rtl/pe_reg_array.sv
module pe_reg_array
   import pe_pkg::*;
#(
   parameter int N  = 16,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  f_i,
   input  logic [3:0]    tt_i,
   input  logic [2:0]    mode_i,
   input  logic          m_ld_i,
   output logic [N-1:0]  x_o,
   output logic [N-1:0]  y_o,
   output logic [N-1:0]  wr_mask_o,
   output logic          any_o,
   output logic [IW-1:0] first_o
);
   localparam int IW_MIN = (N > 1) ? $clog2(N) : 1;

   if (N < 2) begin : g_chk_n
      initial $fatal(1, "pe_reg_array: N must be at least 2");
   end
   if (IW < IW_MIN) begin : g_chk_iw
      initial $fatal(1, "pe_reg_array: IW too narrow for N");
   end

   logic [N-1:0] x_q, y_q, m_q;
   logic [N-1:0] x_nx, y_nx;

   for (genvar g = 0; g < N; g++) begin : g_lane
      pe_lane u_lane (
         .x_i    (x_q[g]),
         .y_i    (y_q[g]),
         .f_i    (f_i[g]),
         .tt_i   (tt_i),
         .mode_i (mode_i),
         .x_nx_o (x_nx[g]),
         .y_nx_o (y_nx[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
         m_q <= '0;
      end else begin
         x_q <= x_nx;
         y_q <= y_nx;
         if (m_ld_i) m_q <= f_i;
      end
   end

   pe_resolver #(.N(N), .IW(IW)) u_res (
      .y_i     (y_q),
      .any_o   (any_o),
      .first_o (first_o)
   );

   assign x_o       = x_q;
   assign y_o       = y_q;
   assign wr_mask_o = m_q;

   // ---------------- assertions ----------------
   assert_y_hold_x_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd0) |=> (y_q == $past(y_q)));

   assert_x_hold_y_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd1) |=> (x_q == $past(x_q)));

   assert_ymask_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd3) |=> ((y_q == $past(y_q)) &&
                            ((x_q & ~$past(y_q)) == ($past(x_q) & ~$past(y_q)))));

   assert_oldy_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd4) |=> ((x_q & ~$past(y_q)) == ($past(x_q) & ~$past(y_q))));

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i > 3'd4) |=> ((x_q == $past(x_q)) && (y_q == $past(y_q))));

   assert_m_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      m_ld_i |=> (wr_mask_o == $past(f_i)));

   assert_m_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !m_ld_i |=> $stable(wr_mask_o));

   assert_none_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !any_o |-> ((y_q == '0) && (first_o == '0)));

   assert_first_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> y_q[first_o]);
endmodule

// File: tb/tb_pe_reg_array.sv
module tb_pe_reg_array;
   localparam int N  = 16;
   localparam int IW = 4;
   localparam int FW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  f_i = '0;
   logic [3:0]    tt_i = '0;
   logic [2:0]    mode_i = 3'd5;
   logic          m_ld_i = 1'b0;
   logic [N-1:0]  x_o, y_o, wr_mask_o;
   logic          any_o;
   logic [IW-1:0] first_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   pe_reg_array #(.N(N), .IW(IW)) dut (
      .clk(clk), .rst_n(rst_n), .f_i(f_i), .tt_i(tt_i), .mode_i(mode_i),
      .m_ld_i(m_ld_i), .x_o(x_o), .y_o(y_o), .wr_mask_o(wr_mask_o),
      .any_o(any_o), .first_o(first_o)
   );

   // entry: mode(3) tt(4) f(16) exp_x(16) exp_y(16)
   localparam int NV = 12;
   localparam logic [54:0] VEC [NV] = '{
      {3'd1, 4'hA, 16'hF0F0, 16'h0000, 16'hF0F0},  // R4 copy into Y
      {3'd0, 4'hA, 16'h3C3C, 16'h3C3C, 16'hF0F0},  // R3 copy into X
      {3'd2, 4'h6, 16'hFF00, 16'hC33C, 16'h0FF0},  // R5 xor both
      {3'd3, 4'hF, 16'h0000, 16'hCFFC, 16'h0FF0},  // R6 set under Y
      {3'd4, 4'h0, 16'hFFFF, 16'hC00C, 16'h0000},  // R7 clear under old Y
      {3'd5, 4'hF, 16'hFFFF, 16'hC00C, 16'h0000},  // R8 idle
      {3'd1, 4'hE, 16'h0101, 16'hC00C, 16'h0101},  // R2 or
      {3'd0, 4'h8, 16'h00FF, 16'h000C, 16'h0101},  // R2 and
      {3'd2, 4'h1, 16'h0F0F, 16'hF0F0, 16'hF0F0},  // R2 nor
      {3'd7, 4'h0, 16'h0000, 16'hF0F0, 16'hF0F0},  // R8 idle
      {3'd0, 4'h3, 16'h1234, 16'h0F0F, 16'hF0F0},  // R2 not-register
      {3'd4, 4'h7, 16'h00FF, 16'hFFFF, 16'hFF0F}   // R7 nand, old-Y mask
   };

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic [2:0] md, input logic [3:0] tt,
                       input logic [N-1:0] f, input logic ld);
      @(negedge clk);
      mode_i = md; tt_i = tt; f_i = f; m_ld_i = ld;
      @(posedge clk);
      #1;
      mode_i = 3'd5; m_ld_i = 1'b0;
   endtask

   function automatic logic [N-1:0] low_idx(input logic [N-1:0] y);
      for (int i = 0; i < N; i++) if (y[i]) return N'(i);
      return '0;
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 x", x_o, '0);
      chk("R1 y", y_o, '0);
      chk("R1 mask", wr_mask_o, '0);
      chk("R1 any", N'(any_o), '0);
      chk("R1 first", N'(first_o), '0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         step(VEC[v][54:52], VEC[v][51:48], VEC[v][47:32], 1'b0);
         chk($sformatf("R2-table x row %0d", v), x_o, VEC[v][31:16]);
         chk($sformatf("R2-table y row %0d", v), y_o, VEC[v][15:0]);
         chk("R10 any", N'(any_o), N'(VEC[v][15:0] != '0));
         chk("R11 first", N'(first_o), low_idx(VEC[v][15:0]));
         chk("R9 mask hold", wr_mask_o, '0);
      end

      // R9 load M regardless of idle mode, then hold
      step(3'd6, 4'h0, 16'hA5A5, 1'b1);
      chk("R9 mask load", wr_mask_o, 16'hA5A5);
      step(3'd2, 4'hA, 16'hFFFF, 1'b0);
      chk("R9 mask hold", wr_mask_o, 16'hA5A5);
      chk("R5 copy both x", x_o, 16'hFFFF);
      chk("R5 copy both y", y_o, 16'hFFFF);

      // R10 R11 resolver corners
      step(3'd1, 4'hA, 16'h8000, 1'b0);
      chk("R11 top lane any", N'(any_o), 1);
      chk("R11 top lane idx", N'(first_o), 15);
      step(3'd1, 4'hA, 16'h0006, 1'b0);
      chk("R11 lowest idx", N'(first_o), 1);
      step(3'd1, 4'hA, 16'h0001, 1'b0);
      chk("R11 lane0 idx", N'(first_o), 0);
      chk("R10 lane0 any", N'(any_o), 1);
      step(3'd1, 4'h0, 16'h0000, 1'b0);
      chk("R10 empty any", N'(any_o), 0);
      chk("R10 empty idx", N'(first_o), 0);

      // R12 four-step add over bit slices
      begin
         logic [FW-1:0] a [N];
         logic [FW-1:0] b [N];
         logic [N-1:0]  sum_sl [FW];
         for (int i = 0; i < N; i++) begin
            a[i] = FW'(i * 17 + 3);
            b[i] = FW'(i * 29 + 200);
         end
         step(3'd2, 4'h0, '0, 1'b0);   // X = 0, Y = 0 (carry in)
         for (int j = 0; j < FW; j++) begin
            logic [N-1:0] sa, sb;
            for (int i = 0; i < N; i++) begin
               sa[i] = a[i][j];
               sb[i] = b[i][j];
            end
            step(3'd4, 4'h6, sa, 1'b0);
            step(3'd4, 4'h6, sb, 1'b0);
            sum_sl[j] = y_o;
            step(3'd3, 4'h3, '0, 1'b0);
            step(3'd2, 4'h6, x_o, 1'b0);
         end
         for (int i = 0; i < N; i++) begin
            logic [FW:0] s;
            logic [FW-1:0] got;
            s = {1'b0, a[i]} + {1'b0, b[i]};
            for (int j = 0; j < FW; j++) got[j] = sum_sl[j][i];
            chk($sformatf("R12 sum lane %0d", i), N'(got), N'(s[FW-1:0]));
            chk($sformatf("R12 carry lane %0d", i), N'(y_o[i]), N'(s[FW]));
         end
         chk("R12 x cleared", x_o, '0);
      end

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule